// File: doc/BRIEF.md
# Oversampling Serial Receiver With Error Flags

This block is the receive half of an asynchronous serial port. It watches a serial input line on every pulse of an enable that runs at sixteen times the bit rate. A high-to-low transition on the idle line starts a frame. The receiver samples the first data bit 24 enable pulses after that transition, which is near the middle of the bit. After that it samples one bit every 16 pulses. The data bits arrive least significant first and are shifted into a register. When the frame completes, the character moves into a holding buffer that the host reads.

The word length, parity mode and stop-bit count are static inputs shared with the transmit half. The host uses two read strobes. One takes the character from the buffer. The other acknowledges the status flags. The status vector reports:

- data-ready
- overrun
- parity error
- framing error
- break

Top module: `osr_serial_rx`

## Requirements
- R1: After a synchronous active-low reset, `stat` is 00000 and `rx_buf` is zero.
- R2: The receiver arms only when the line was high at one `tick_x16` and is low at the next. The first data sample is taken on the 24th `tick_x16` after that arming tick.
- R3: Each later bit is sampled 16 ticks after the previous one. Data arrives LSB first. `cfg_wlen` selects 00=5, 01=6, 10=7 or 11=8 data bits. Buffer bits above the word length read as zero.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. The check depends on the mode:
  - With `cfg_par_stick`=0: even parity if `cfg_par_even`=1, odd parity if 0.
  - With `cfg_par_stick`=1: the expected parity bit equals the inverse of `cfg_par_even`.
  - A mismatch sets `stat[2]`.
- R5: When `cfg_par_en` is 0, no parity bit is sampled and `stat[2]` is not set.
- R6: Only the first stop bit is sampled, and a low sample sets `stat[3]`. The receiver re-arms right after that sample, so frames sent with two stop bits are received correctly.
- R7: If every data, parity and stop sample of a frame is low, `stat[4]` (break) is set together with `stat[3]`.
- R8: A completed frame loads `rx_buf` and sets `stat[0]`. A pulse on `rd_buf` clears `stat[0]`.
- R9: A frame that completes while `stat[0]` is set and `rd_buf` is low sets `stat[1]`. In that case `rx_buf` keeps the older character and the dropped frame's parity, framing and break results are discarded.
- R10: A pulse on `rd_stat` clears `stat[4:1]` and leaves `stat[0]` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_x16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial input, already synchronised, idle high |
| cfg_wlen | input | 2 | Word length select (00=5 to 11=8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select; in stick mode, inverse of the expected bit |
| cfg_par_stick | input | 1 | Stick parity mode |
| rd_buf | input | 1 | Host read of the character buffer |
| rd_stat | input | 1 | Host read of the status flags |
| rx_buf | output | 8 | Received character |
| stat | output | 5 | Status flags: bit0 ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break |

## Verification
The bench builds the block with its defaults: eight-bit maximum word length and 16x oversampling. This means the 24-tick first-sample delay and the 16-tick bit step are the real values. Tick-aligned single-pulse frames are used to check that a sample lands on exactly the intended tick. The table walks every word length, each parity mode including both stick levels, and two-stop-bit framing. Directed runs then cover the all-low break frame and overrun with its discarded error flags.

// File: rtl/rxo_pkg.sv
// Package rxo_pkg
// Shared types for the oversampling serial receiver.
// Assumes the status vector layout is fixed: ready, overrun, parity, framing, break.
package rxo_pkg;

    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_PAR  = 2'd1,
        PH_STOP = 2'd2
    } rx_phase_e;

    localparam int ST_READY = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_PERR  = 2;
    localparam int ST_FERR  = 3;
    localparam int ST_BRK   = 4;
    localparam int ST_W     = 5;

endpackage

// File: rtl/rxo_bit_timer.sv
// Module rxo_bit_timer
// Detects the start edge on the serial line and produces a one-cycle sample
// strobe at each bit centre: OSR + OSR/2 ticks after arming, then every OSR ticks.
// Assumes rxd is already synchronised and frame_done only arrives with samp.
module rxo_bit_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic frame_done,
    output logic samp,
    output logic busy
);
    localparam int FIRST = OSR + OSR / 2;
    localparam int CW    = $clog2(FIRST + 1);

    logic          prev_q;
    logic [CW-1:0] cnt_q;

    assign samp = tick && busy && (cnt_q == '0);

    // Line level seen at the previous tick, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= rxd;
    end

    // Arm on a high-to-low edge and count ticks down to each sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (frame_done) begin
            busy  <= 1'b0;
        end else if (tick) begin
            if (!busy) begin
                if (prev_q && !rxd) begin
                    busy  <= 1'b1;
                    cnt_q <= CW'(FIRST - 1);
                end
            end else if (cnt_q == '0) begin
                cnt_q <= CW'(OSR - 1);
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Checker state: ticks elapsed since arming or since the last sample.
    logic [CW-1:0] chk_ticks;
    logic          chk_first;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_ticks <= '0;
            chk_first <= 1'b0;
        end else if (tick) begin
            if (!busy) begin
                chk_ticks <= '0;
                chk_first <= 1'b1;
            end else if (samp) begin
                chk_ticks <= '0;
                chk_first <= 1'b0;
            end else begin
                chk_ticks <= chk_ticks + 1'b1;
            end
        end
    end

    a_r2_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (samp && chk_first) |-> (chk_ticks == CW'(FIRST - 1)));
    a_r3_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (samp && !chk_first) |-> (chk_ticks == CW'(OSR - 1)));
    a_r2_arm_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!rxd));

endmodule

// File: rtl/rxo_frame_asm.sv
// Module rxo_frame_asm
// Walks the data, parity and stop phases on each sample strobe, shifts
// data in LSB first and reports the character plus parity, framing and break
// results in the cycle of the stop sample. Assumes configuration is stable during a frame.
module rxo_frame_asm
    import rxo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp,
    input  logic              sval,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    output logic              done,
    output logic [DATA_W-1:0] chr,
    output logic              perr,
    output logic              ferr,
    output logic              brk
);
    localparam int MIN_W = DATA_W - 3;
    localparam int IW    = $clog2(DATA_W + 1);

    rx_phase_e         phase_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_acc_q;
    logic              par_bit_q;
    logic              any_hi_q;
    logic [IW-1:0]     nbits;

    assign nbits = IW'(MIN_W) + IW'(cfg_wlen);

    // Completion strobe and result decode at the first stop sample.
    always_comb begin
        done = samp && (phase_q == PH_STOP);
        chr  = shreg_q >> (IW'(DATA_W) - nbits);
        ferr = !sval;
        brk  = !(any_hi_q || sval);
        if (!cfg_par_en)        perr = 1'b0;
        else if (cfg_par_stick) perr = (par_bit_q == cfg_par_even);
        else                    perr = ((par_acc_q ^ par_bit_q) == cfg_par_even);
    end

    // Phase sequencing and accumulation of the sampled bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_DATA;
            idx_q     <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            par_bit_q <= 1'b0;
            any_hi_q  <= 1'b0;
        end else if (samp) begin
            unique case (phase_q)
                PH_DATA: begin
                    shreg_q   <= {sval, shreg_q[DATA_W-1:1]};
                    par_acc_q <= par_acc_q ^ sval;
                    any_hi_q  <= any_hi_q | sval;
                    if (idx_q == nbits - 1'b1) begin
                        idx_q   <= '0;
                        phase_q <= cfg_par_en ? PH_PAR : PH_STOP;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_PAR: begin
                    par_bit_q <= sval;
                    any_hi_q  <= any_hi_q | sval;
                    phase_q   <= PH_STOP;
                end
                default: begin
                    phase_q   <= PH_DATA;
                    idx_q     <= '0;
                    par_acc_q <= 1'b0;
                    par_bit_q <= 1'b0;
                    any_hi_q  <= 1'b0;
                end
            endcase
        end
    end

    a_r5_no_parity_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_par_en |-> (phase_q != PH_PAR));
    a_r7_break_is_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (done && brk) |-> ferr);
    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |-> (idx_q < nbits));

endmodule

// File: rtl/rxo_status_regs.sv
// Module rxo_status_regs
// Holds the received character and the five status flags. A character is
// accepted unless the buffer is still full, in which case overrun is raised.
// Assumes done is a single-cycle strobe from the frame assembler.
module rxo_status_regs
    import rxo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] chr,
    input  logic              perr,
    input  logic              ferr,
    input  logic              brk,
    input  logic              rd_buf,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] buf_q,
    output logic [ST_W-1:0]   stat
);
    logic       ready_q;
    logic       ovr_q;
    logic [2:0] err_q;
    logic       accept;

    assign accept = done && (!ready_q || rd_buf);
    assign stat   = {err_q[2], err_q[1], err_q[0], ovr_q, ready_q};

    // Buffer load and data-ready tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            ready_q <= 1'b0;
        end else if (accept) begin
            buf_q   <= chr;
            ready_q <= 1'b1;
        end else if (rd_buf) begin
            ready_q <= 1'b0;
        end
    end

    // Sticky error flags, cleared by a status read; a new set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            err_q <= '0;
        end else begin
            ovr_q <= (done && !accept) || (ovr_q && !rd_stat);
            err_q <= (rd_stat ? 3'b000 : err_q) | (accept ? {brk, ferr, perr} : 3'b000);
        end
    end

    a_r9_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stat[ST_READY] && !rd_buf) |=> (stat[ST_OVR] && $stable(buf_q)));
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf && !done) |=> !stat[ST_READY]);
    a_r8_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> stat[ST_READY]);
    a_r10_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !done) |=> (stat[ST_BRK:ST_OVR] == 4'b0000));

endmodule

// File: rtl/osr_serial_rx.sv
// Module osr_serial_rx
// Top of the oversampling serial receiver: bit timer, frame assembler and
// status registers. Assumes rxd is synchronised to clk and tick_x16 is a
// single-cycle enable at sixteen times the bit rate.
module osr_serial_rx
    import rxo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_x16,
    input  logic              rxd,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              rd_buf,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] rx_buf,
    output logic [ST_W-1:0]   stat
);
    logic              samp;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] chr;
    logic              perr;
    logic              ferr;
    logic              brk;

    rxo_bit_timer #(.OSR(OSR)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_x16),
        .rxd        (rxd),
        .frame_done (done),
        .samp       (samp),
        .busy       (busy)
    );

    rxo_frame_asm #(.DATA_W(DATA_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .samp          (samp),
        .sval          (rxd),
        .cfg_wlen      (cfg_wlen),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_par_stick (cfg_par_stick),
        .done          (done),
        .chr           (chr),
        .perr          (perr),
        .ferr          (ferr),
        .brk           (brk)
    );

    rxo_status_regs #(.DATA_W(DATA_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .chr     (chr),
        .perr    (perr),
        .ferr    (ferr),
        .brk     (brk),
        .rd_buf  (rd_buf),
        .rd_stat (rd_stat),
        .buf_q   (rx_buf),
        .stat    (stat)
    );

    a_r8_done_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: tb/sim_osr_serial_rx.sv
module sim_osr_serial_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_x16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       rd_buf = 1'b0;
    logic       rd_stat = 1'b0;
    logic [7:0] rx_buf;
    logic [4:0] stat;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Tick on every second cycle, driven at the falling edge.
    always @(negedge clk) tick_x16 <= ~tick_x16;

    osr_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick_x16(tick_x16), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .rd_buf(rd_buf), .rd_stat(rd_stat),
        .rx_buf(rx_buf), .stat(stat)
    );

    // Entry: [28]two_stop [27:26]wlen [25]par_en [24]even [23]stick [22:15]data
    //        [14]bad_par [13]bad_stop [12:5]exp_data [4:0]exp_stat
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 5'b00001},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 5'b00001},
        {1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b0, 8'h2A, 5'b00001},
        {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 8'h41, 1'b0, 1'b0, 8'h41, 5'b00001},
        {1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 5'b00101},
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 8'h55, 5'b01001},
        {1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 8'h81, 5'b00001},
        {1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 8'h81, 1'b1, 1'b0, 8'h81, 5'b00101},
        {1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 5'b11001},
        {1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0, 8'h7E, 5'b00001},
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00001},
        {1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h7F, 5'b00001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (31) @(negedge clk);
    endtask

    task automatic send(input logic two_stop, input logic [1:0] wl, input logic pen,
                        input logic even, input logic stick, input logic [7:0] d,
                        input logic bad_par, input logic bad_stop);
        int   n;
        logic p;
        n = 5 + int'(wl);
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_even = even; cfg_par_stick = stick;
        p = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ d[i];
        if (stick)      p = ~even;
        else if (!even) p = ~p;
        p = p ^ bad_par;
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) hold_bit(d[i]);
        if (pen) hold_bit(p);
        hold_bit(~bad_stop);
        if (two_stop) hold_bit(1'b1);
        @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic pulse_rd(input logic which_stat);
        @(negedge clk);
        if (which_stat) rd_stat = 1'b1; else rd_buf = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0; rd_buf = 1'b0;
        @(negedge clk);
    endtask

    task automatic next_tick();
        @(posedge clk);
        while (!tick_x16) @(posedge clk);
    endtask

    // 5-bit frame, no parity, line low except around tick 'hi', stop high.
    task automatic timed_frame(input int hi);
        cfg_wlen = 2'd0; cfg_par_en = 1'b0; cfg_par_stick = 1'b0;
        next_tick();
        #1 rxd = 1'b0;
        next_tick();
        for (int k = 1; k <= 120; k++) begin
            next_tick();
            #1;
            if (k == hi - 1)      rxd = 1'b1;
            else if (k == hi)     rxd = 1'b0;
            else if (k == 96)     rxd = 1'b1;
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset stat", 32'(stat), 32'h0);
        chk("R1 reset buf", 32'(rx_buf), 32'h0);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][28], VEC[v][27:26], VEC[v][25], VEC[v][24], VEC[v][23],
                 VEC[v][22:15], VEC[v][14], VEC[v][13]);
            chk("R3/R4/R6/R7 vec data", 32'(rx_buf), 32'(VEC[v][12:5]));
            chk("R4/R5/R6/R7/R8 vec stat", 32'(stat), 32'(VEC[v][4:0]));
            pulse_rd(1'b1);
            chk("R10 stat read keeps ready", 32'(stat), 32'h1);
            pulse_rd(1'b0);
            chk("R8 buf read clears ready", 32'(stat), 32'h0);
        end

        timed_frame(24);
        chk("R2 first sample at tick 24", 32'(rx_buf), 32'h01);
        chk("R2 stat", 32'(stat), 32'h1);
        pulse_rd(1'b0);
        timed_frame(40);
        chk("R3 second sample 16 ticks on", 32'(rx_buf), 32'h02);
        pulse_rd(1'b0);

        send(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
        send(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
        chk("R9 overrun stat", 32'(stat), 32'h3);
        chk("R9 old char kept", 32'(rx_buf), 32'h11);
        pulse_rd(1'b1);
        chk("R10 overrun cleared", 32'(stat), 32'h1);
        pulse_rd(1'b0);
        send(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0);
        send(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h44, 1'b0, 1'b1);
        chk("R9 dropped frame errors discarded", 32'(stat), 32'h3);
        chk("R9 buf holds first", 32'(rx_buf), 32'h33);
        pulse_rd(1'b1);
        pulse_rd(1'b0);
        chk("R8 all clear", 32'(stat), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule